// File: doc/BRIEF.md
# Break-Aware Serial Character Receiver

This block turns an asynchronous serial line into characters. A free-running clock drives it. An enable pulse arrives at sixteen times the bit rate, and the block steps its frame logic only on the clocks that carry that pulse. It looks for a falling edge and checks that the edge is a real start bit. It then samples each data, parity and stop bit at the centre of the bit and gathers the data, least significant bit first, into a shift register. When the frame ends, the block hands over the character on a one-cycle push strobe. The data byte, a parity-error flag, a framing-error flag and a break flag go out with the strobe.

A line held low through a whole frame is reported as a break. The block then pushes an all-zero character with the break flag set. After a break it ignores the line until the line has been high for half a bit time. A break can begin partway through a character. In that case the damaged character goes out first with its framing error, and a break character follows once the line has stayed low for the next full frame. Character length runs from five to eight bits, and parity can be off, even or odd. There is one stop bit.

Top module: `uart_rx_brk`

## Requirements
- R1: A synchronous active-high reset returns the receiver to hunting for a start bit, drops any partly received frame without a push, clears the post-break hold-off, and holds `rx_push` low.
- R2: While hunting, a low `rxd` on an enabled tick begins a start bit. The line is sampled again on the 8th tick counted from that one. If it is high there, the start is treated as a glitch and dropped: hunting resumes and nothing is pushed.
- R3: After a confirmed start, each later bit is sampled 16 ticks after the previous sample. Data arrives least significant bit first. `cfg_len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and unused upper bits of `rx_data` read 0.
- R4: Each frame gives exactly one push. `rx_push` is high for a single clock, on the clock after the tick that samples the stop bit, and all four result fields are valid in that clock.
- R5: With `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity, where the XOR of the data bits and the parity bit is 0. A value of 1 selects odd parity, where that XOR is 1. A mismatch sets `rx_perr`. With parity off, `rx_perr` is 0.
- R6: A low stop-bit sample sets `rx_ferr` unless every sample of the frame, start bit included, was low.
- R7: A frame in which every sample is low, the stop bit included, is pushed as a break: `rx_data` = 0, `rx_brk` = 1, `rx_ferr` = 0 and `rx_perr` = 0.
- R8: After a break push, no start bit is accepted until `rxd` has been high on 8 consecutive ticks. Any low tick restarts that count.
- R9: A line that drops low partway through a character and stays low gives two pushes. The damaged character comes first with `rx_ferr` = 1. A break character follows once a complete further frame time has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high, synchronous to `clk` |
| cfg_len_sel | input | 2 | Data length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_push | output | 1 | One-cycle strobe for a finished character |
| rx_data | output | 8 | Received data, right-aligned |
| rx_perr | output | 1 | Parity error of the pushed character |
| rx_ferr | output | 1 | Framing error of the pushed character |
| rx_brk | output | 1 | Pushed character is a break |

## Verification
The tightest overlap comes with a break that starts mid-character. The push of the damaged character and the start detection of the following break frame fall in the same clock. This happens when the enable pulse is present on every clock and the line is still low on the tick after the stop sample. The bench runs that case with a continuous enable. It checks that the push does not disturb the start detection and that the damaged character (framing error set) is followed, one frame later, by the all-zero break character. A behavioural per-tick model, compared on every clock, judges the strobe timing and the fields of both pushes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int LEN_W    = 2;
    localparam int IDX_W    = $clog2(DATA_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLDOFF
    } rx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len_sel;
        logic             par_en;
        logic             par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

    // sample events raised by the frame controller
    typedef struct packed {
        logic             arm;
        logic             dbit;
        logic             pbit;
        logic             sbit;
        logic [IDX_W-1:0] idx;
    } rx_evt_t;

    function automatic logic [IDX_W-1:0] last_idx(input logic [LEN_W-1:0] sel);
        return IDX_W'(MIN_BITS - 1) + IDX_W'(sel);
    endfunction

    function automatic logic par_mismatch(input logic [DATA_W-1:0] d,
                                          input logic p,
                                          input logic odd);
        return (^d) ^ p ^ odd;
    endfunction

endpackage

// File: rtl/rx_phase_ctr.sv
module rx_phase_ctr #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic mid
);
    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] MID_PH = PH_W'(OSR / 2 - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (tick)
            phase <= clear ? '0 : phase + PH_W'(1);
    end

    assign mid = (phase == MID_PH);

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      mid,
    input  logic      zero_run,
    input  rx_cfg_t   cfg,
    output rx_state_e state,
    output logic      clear,
    output rx_evt_t   evt
);
    logic [IDX_W-1:0] bit_idx;

    always_comb begin
        evt     = '0;
        evt.idx = bit_idx;
        if (tick && mid) begin
            case (state)
                RX_START: evt.arm  = ~rxd;
                RX_DATA:  evt.dbit = 1'b1;
                RX_PAR:   evt.pbit = 1'b1;
                RX_STOP:  evt.sbit = 1'b1;
                default:  ;
            endcase
        end
        clear = tick && ((((state == RX_IDLE) || (state == RX_HOLDOFF)) && !rxd)
                         || ((state == RX_STOP) && mid));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            bit_idx <= '0;
        end else if (tick) begin
            case (state)
                RX_IDLE:
                    if (!rxd) state <= RX_START;
                RX_START:
                    if (mid) begin
                        state   <= rxd ? RX_IDLE : RX_DATA;
                        bit_idx <= '0;
                    end
                RX_DATA:
                    if (mid) begin
                        if (bit_idx == last_idx(cfg.len_sel))
                            state <= cfg.par_en ? RX_PAR : RX_STOP;
                        bit_idx <= bit_idx + IDX_W'(1);
                    end
                RX_PAR:
                    if (mid) state <= RX_STOP;
                RX_STOP:
                    if (mid) state <= (zero_run && !rxd) ? RX_HOLDOFF : RX_IDLE;
                RX_HOLDOFF:
                    if (rxd && mid) state <= RX_IDLE;
                default:
                    state <= RX_IDLE;
            endcase
        end
    end

    AST_HOLDOFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HOLDOFF) && tick && !rxd |=> state == RX_HOLDOFF); // R8

    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START) && tick && mid && rxd |=> state == RX_IDLE); // R2

endmodule

// File: rtl/rx_char_asm.sv
module rx_char_asm
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rxd,
    input  rx_evt_t  evt,
    input  rx_cfg_t  cfg,
    output logic     push,
    output rx_char_t chr,
    output logic     zero_run
);
    logic [DATA_W-1:0] shreg;
    logic              par_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            push     <= 1'b0;
            chr      <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            zero_run <= 1'b0;
        end else begin
            push <= evt.sbit;
            if (evt.arm) begin
                shreg    <= '0;
                par_bit  <= 1'b0;
                zero_run <= 1'b1;
            end
            if (evt.dbit) begin
                shreg[evt.idx] <= rxd;
                zero_run       <= zero_run & ~rxd;
            end
            if (evt.pbit) begin
                par_bit  <= rxd;
                zero_run <= zero_run & ~rxd;
            end
            if (evt.sbit) begin
                if (zero_run && !rxd) begin
                    chr <= '{data: '0, perr: 1'b0, ferr: 1'b0, brk: 1'b1};
                end else begin
                    chr.data <= shreg;
                    chr.perr <= cfg.par_en & par_mismatch(shreg, par_bit, cfg.par_odd);
                    chr.ferr <= ~rxd;
                    chr.brk  <= 1'b0;
                end
            end
        end
    end

    AST_STOP_HIGH_CLEAN: assert property (@(posedge clk) disable iff (rst)
        evt.sbit && rxd |=> push && !chr.ferr && !chr.brk); // R6

    AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (rst)
        push && chr.brk |-> (chr.data == '0) && !chr.ferr && !chr.perr); // R7

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [LEN_W-1:0]  cfg_len_sel,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk
);
    rx_cfg_t   cfg;
    rx_state_e st;
    rx_evt_t   evt;
    rx_char_t  chr;
    logic      clear;
    logic      mid;
    logic      zero_run;

    assign cfg = '{len_sel: cfg_len_sel, par_en: cfg_par_en, par_odd: cfg_par_odd};

    rx_phase_ctr #(.OSR(OSR)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .clear (clear),
        .mid   (mid)
    );

    rx_frame_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rxd      (rxd),
        .mid      (mid),
        .zero_run (zero_run),
        .cfg      (cfg),
        .state    (st),
        .clear    (clear),
        .evt      (evt)
    );

    rx_char_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .rxd      (rxd),
        .evt      (evt),
        .cfg      (cfg),
        .push     (rx_push),
        .chr      (chr),
        .zero_run (zero_run)
    );

    assign rx_data = chr.data;
    assign rx_perr = chr.perr;
    assign rx_ferr = chr.ferr;
    assign rx_brk  = chr.brk;

    AST_PUSH_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> $past(st) == RX_STOP); // R4

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_push); // R4

    AST_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (rst)
        rx_push && !cfg_par_en |-> !rx_perr); // R5

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st == RX_IDLE) && !rx_push); // R1

endmodule

// File: tb/uart_rx_brk_test.sv
`timescale 1ns/1ps
module uart_rx_brk_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rx_push;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    int n_chk = 0;
    int n_fail = 0;
    bit fast = 1'b0;
    bit done = 1'b0;
    int run = 0;
    int max_run = 0;
    logic [10:0] dut_q[$];

    uart_rx_brk uut (
        .clk(clk), .rst(rst), .tick16(tick), .rxd(rxd),
        .cfg_len_sel(len_sel), .cfg_par_en(par_en), .cfg_par_odd(par_odd),
        .rx_push(rx_push), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) tick <= fast ? 1'b1 : ~tick;

    // behavioural per-tick reference model
    int  m_mode = 0;
    int  m_t = 0;
    int  m_hi = 0;
    bit  m_bits[$];
    logic       exp_v = 1'b0;
    logic [7:0] exp_d = '0;
    logic       exp_pe = 1'b0, exp_fe = 1'b0, exp_bk = 1'b0;

    always @(posedge clk) begin
        logic pu, pe, fe, bk, p, allz;
        logic [7:0] d;
        int nb;
        pu = 0; pe = 0; fe = 0; bk = 0; d = '0;
        nb = 5 + int'(len_sel);
        if (rst) begin
            m_mode = 0;
            m_hi = 0;
        end else if (tick) begin
            if (m_mode == 0) begin
                if (!rxd) begin
                    m_mode = 1;
                    m_t = 0;
                    m_bits.delete();
                end
            end else if (m_mode == 1) begin
                if (m_t % 16 == 7) begin
                    if (m_t == 7) begin
                        if (rxd) m_mode = 0;
                    end else begin
                        m_bits.push_back(rxd);
                    end
                end
                if (m_mode == 1 && m_bits.size() == nb + int'(par_en) + 1) begin
                    allz = 1;
                    foreach (m_bits[i]) if (m_bits[i]) allz = 0;
                    pu = 1;
                    if (allz) begin
                        bk = 1;
                        m_mode = 2;
                        m_hi = 0;
                    end else begin
                        for (int i = 0; i < nb; i++) d[i] = m_bits[i];
                        p = par_en ? m_bits[nb] : 1'b0;
                        pe = par_en && ((^d) ^ p ^ par_odd);
                        fe = !m_bits[m_bits.size() - 1];
                        m_mode = 0;
                    end
                end
                m_t++;
            end else begin
                if (rxd) begin
                    m_hi++;
                    if (m_hi == 8) m_mode = 0;
                end else begin
                    m_hi = 0;
                end
            end
        end
        exp_v  <= pu;
        exp_d  <= d;
        exp_pe <= pe;
        exp_fe <= fe;
        exp_bk <= bk;
    end

    // per-clock comparison and push monitor
    always @(negedge clk) begin
        if (rx_push !== exp_v) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 push strobe actual %b expected %b at %0t", rx_push, exp_v, $time);
        end else if (exp_v) begin
            n_chk++;
            if ({rx_data, rx_perr, rx_ferr, rx_brk} !== {exp_d, exp_pe, exp_fe, exp_bk}) begin
                n_fail++;
                $display("FAIL %s model fields actual %h expected %h",
                         exp_bk ? "R7" : exp_fe ? "R6" : exp_pe ? "R5" : "R3",
                         {rx_data, rx_perr, rx_ferr, rx_brk}, {exp_d, exp_pe, exp_fe, exp_bk});
            end
        end
        if (rx_push === 1'b1) begin
            dut_q.push_back({rx_data, rx_perr, rx_ferr, rx_brk});
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic check(input string req, input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(posedge clk iff tick);
        @(negedge clk);
    endtask

    task automatic set_cfg(input int nb, input bit pen, input bit podd);
        len_sel = 2'(nb - 5);
        par_en  = pen;
        par_odd = podd;
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit podd, input bit flip, input bit stop_low);
        logic p;
        p = podd;
        for (int i = 0; i < nb; i++) p ^= d[i];
        if (flip) p = ~p;
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (pen) hold(p, 16);
        if (stop_low) hold(1'b0, 9);
        else hold(1'b1, 16);
        hold(1'b1, 24);
    endtask

    task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe,
                               input bit bk, input string req);
        logic [10:0] e, a;
        e = {d, pe, fe, bk};
        if (dut_q.size() == 0) begin
            check(req, 1'b0, $sformatf("actual no push expected %h", e));
        end else begin
            a = dut_q.pop_front();
            check(req, a === e, $sformatf("actual %h expected %h", a, e));
        end
    endtask

    task automatic expect_none(input string req);
        check(req, dut_q.size() == 0,
              $sformatf("actual %0d pushes expected 0", dut_q.size()));
        dut_q.delete();
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", rx_push === 1'b0, $sformatf("reset push actual %b expected 0", rx_push));
        rst = 1'b0;
        hold(1'b1, 20);

        // R3: 8 data bits, no parity
        set_cfg(8, 0, 0);
        send_frame(8'hA5, 8, 0, 0, 0, 0);
        expect_char(8'hA5, 0, 0, 0, "R3");

        // R5: 5 bits even parity, good then bad
        set_cfg(5, 1, 0);
        send_frame(8'h15, 5, 1, 0, 0, 0);
        expect_char(8'h15, 0, 0, 0, "R5");
        send_frame(8'h15, 5, 1, 0, 1, 0);
        expect_char(8'h15, 1, 0, 0, "R5");

        // R5: 7 bits odd parity, good then bad
        set_cfg(7, 1, 1);
        send_frame(8'h41, 7, 1, 1, 0, 0);
        expect_char(8'h41, 0, 0, 0, "R5");
        send_frame(8'h41, 7, 1, 1, 1, 0);
        expect_char(8'h41, 1, 0, 0, "R5");

        // R3: 6 bits, parity off, odd flag ignored
        set_cfg(6, 0, 1);
        send_frame(8'h2B, 6, 0, 0, 0, 0);
        expect_char(8'h2B, 0, 0, 0, "R3");

        // R6: low stop bit
        set_cfg(8, 0, 0);
        send_frame(8'h3C, 8, 0, 0, 0, 1);
        expect_char(8'h3C, 0, 1, 0, "R6");
        expect_none("R2");

        // R2: short low pulse is a glitch
        hold(1'b0, 5);
        hold(1'b1, 30);
        expect_none("R2");

        // R7 / R8: full break then hold-off
        hold(1'b0, 16 * 30);
        expect_char(8'h00, 0, 0, 1, "R7");
        expect_none("R8");
        hold(1'b1, 4);
        hold(1'b0, 20);
        hold(1'b1, 4);
        expect_none("R8");
        hold(1'b1, 12);
        send_frame(8'h96, 8, 0, 0, 0, 0);
        expect_char(8'h96, 0, 0, 0, "R8");

        // R9: break starting mid-character, enable on every clock
        fast = 1'b1;
        @(negedge clk);
        hold(1'b0, 16);
        hold(1'b1, 16 * 3);
        hold(1'b0, 16 * 18);
        expect_char(8'h07, 0, 1, 0, "R9");
        expect_char(8'h00, 0, 0, 1, "R9");
        expect_none("R9");
        hold(1'b1, 20);
        send_frame(8'h5A, 8, 0, 0, 0, 0);
        expect_char(8'h5A, 0, 0, 0, "R9");
        fast = 1'b0;
        @(negedge clk);

        // R1: reset clears the hold-off
        hold(1'b0, 16 * 12);
        expect_char(8'h00, 0, 0, 1, "R7");
        hold(1'b1, 3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        send_frame(8'hC3, 8, 0, 0, 0, 0);
        expect_char(8'hC3, 0, 0, 0, "R1");

        // R1: reset mid-frame drops the character
        hold(1'b0, 16);
        hold(1'b1, 16);
        hold(1'b0, 8);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hold(1'b1, 40);
        expect_none("R1");

        check("R4", max_run == 1, $sformatf("push width actual %0d expected 1", max_run));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual hung expected finished run");
            summary();
            $finish;
        end
    end

endmodule